// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block sits next to a small CPU and decides which clock domains run while the processor sleeps. Software picks one of six low-power modes with a 3-bit select, sets a sleep-enable bit and then issues a sleep strobe. The controller then gates the clock enables for the CPU, the program and data memories, the general I/O peripherals, the ADC, the asynchronous timer and the main oscillator. Each mode has its own set of domains that keep running.

While asleep, the block watches four wake sources: an external interrupt, a general peripheral interrupt, an ADC interrupt and an asynchronous timer interrupt. Each mode accepts only some of these sources; a source that the mode does not accept leaves the block asleep. A hardware reset always wakes it. After an accepted wake event, the block delays the return of the CPU clock for a time that depends on the mode. The delay is none when the oscillator kept running for the CPU-side domains. It is a fixed six cycles when only the oscillator was kept. It is a start-up count from software when the oscillator was stopped.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: While `rst_ni` is low, and at once when it falls (without waiting for a clock edge), all six clock enables and `wake_ready_o` are 1.
- R2: In the awake state, a cycle with `sleep_strobe_i`=1 and `sleep_en_i`=1 enters sleep at that clock edge. With `sleep_en_i`=0 the strobe is ignored and all enables stay 1.
- R3: Mode codes 000 (Idle) and the reserved codes 100 and 101 keep every domain running except the CPU. In the bench order {osc,atmr,adc,io,mem,cpu} this is 111110.
- R4: Mode code 001 (ADC noise reduction) keeps only the ADC, asynchronous timer and oscillator enables on (111000).
- R5: Mode code 010 (power-down) turns every enable off (000000). Mode code 011 (power-save) keeps only the asynchronous timer (010000).
- R6: Mode code 110 (standby) keeps only the oscillator (100000). Mode code 111 (extended standby) keeps the oscillator and the asynchronous timer (110000).
- R7: Accepted wake sources, in the order {atmr,adc,periph,ext}, are:
  - Idle/reserved: 1111
  - ADC noise reduction: 1101
  - power-down: 0001
  - power-save: 1001
  - standby: 0001
  - extended standby: 1001

  A source outside the accepted set leaves the enables unchanged and the block asleep.
- R8: After an accepted wake event, `wake_ready_o` returns after a number of cycles that depends on the mode:
  - Idle/reserved and ADC noise reduction: returns at the next clock, with no delay cycles.
  - Standby and extended standby: 6 cycles.
  - Power-down and power-save: `startup_cnt_i` cycles, sampled at the wake edge, with a count of 0 treated as 1.
- R9: During the restart delay, the oscillator enable is 1, the asynchronous timer enable keeps its sleep value, and the CPU, memory, I/O and ADC enables are 0. Once awake, all enables are 1. `wake_ready_o` is 1 only in the awake state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_en_i | input | 1 | Sleep enable bit |
| mode_sel_i | input | 3 | Low-power mode select |
| sleep_strobe_i | input | 1 | Sleep instruction strobe |
| startup_cnt_i | input | CNT_W | Oscillator start-up delay in cycles |
| wake_ext_i | input | 1 | External interrupt wake source |
| wake_periph_i | input | 1 | General peripheral interrupt wake source |
| wake_adc_i | input | 1 | ADC interrupt wake source |
| wake_atmr_i | input | 1 | Asynchronous timer interrupt wake source |
| clk_en_cpu_o | output | 1 | CPU clock enable |
| clk_en_mem_o | output | 1 | Flash and SRAM clock enable |
| clk_en_io_o | output | 1 | General I/O peripheral clock enable |
| clk_en_adc_o | output | 1 | ADC clock enable |
| clk_en_atmr_o | output | 1 | Asynchronous timer clock enable |
| clk_en_osc_o | output | 1 | Main oscillator enable |
| wake_ready_o | output | 1 | Controller awake, CPU clock running |

## Verification
The sleep strobe and a wake event each act at the first rising edge after they are driven. The enables change just after that edge, so the bench drives inputs on falling edges and samples one falling edge later. After a wake event, the bench counts the falling edges at which `wake_ready_o` is still low and compares this count with the mode's expected delay: 0, 6, or the start-up count (with 0 raised to 1). On each of those falling edges it also checks the restart enable pattern. The reset check samples one nanosecond after `rst_ni` falls, in the middle of a cycle, so that it sees the asynchronous effect before any edge.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  localparam int MODE_W = 3;
  localparam int NUM_WAKE = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_IDLE  = 3'b000,
    MODE_ADCNR = 3'b001,
    MODE_PDOWN = 3'b010,
    MODE_PSAVE = 3'b011,
    MODE_STBY  = 3'b110,
    MODE_XSTBY = 3'b111
  } sleep_mode_e;

  typedef enum logic [1:0] {
    RSTRT_NONE  = 2'd0,
    RSTRT_FIXED = 2'd1,
    RSTRT_PROG  = 2'd2
  } restart_kind_e;

  typedef struct packed {
    logic osc;
    logic atmr;
    logic adc;
    logic io;
    logic mem;
    logic cpu;
  } clk_dom_t;

  // wake bit order: [3] async timer, [2] adc, [1] peripheral, [0] external
  typedef struct packed {
    clk_dom_t             keep;
    logic [NUM_WAKE-1:0]  wake_ok;
    restart_kind_e        rkind;
  } mode_cfg_t;

  localparam clk_dom_t DOM_ALL_ON = '{osc: 1'b1, atmr: 1'b1, adc: 1'b1,
                                      io: 1'b1, mem: 1'b1, cpu: 1'b1};

  function automatic mode_cfg_t decode_mode(logic [MODE_W-1:0] sel);
    mode_cfg_t c;
    c.keep    = '{osc: 1'b1, atmr: 1'b1, adc: 1'b1, io: 1'b1, mem: 1'b1, cpu: 1'b0};
    c.wake_ok = 4'b1111;
    c.rkind   = RSTRT_NONE;
    case (sel)
      MODE_ADCNR: begin
        c.keep    = '{osc: 1'b1, atmr: 1'b1, adc: 1'b1, io: 1'b0, mem: 1'b0, cpu: 1'b0};
        c.wake_ok = 4'b1101;
      end
      MODE_PDOWN: begin
        c.keep    = '0;
        c.wake_ok = 4'b0001;
        c.rkind   = RSTRT_PROG;
      end
      MODE_PSAVE: begin
        c.keep    = '{osc: 1'b0, atmr: 1'b1, adc: 1'b0, io: 1'b0, mem: 1'b0, cpu: 1'b0};
        c.wake_ok = 4'b1001;
        c.rkind   = RSTRT_PROG;
      end
      MODE_STBY: begin
        c.keep    = '{osc: 1'b1, atmr: 1'b0, adc: 1'b0, io: 1'b0, mem: 1'b0, cpu: 1'b0};
        c.wake_ok = 4'b0001;
        c.rkind   = RSTRT_FIXED;
      end
      MODE_XSTBY: begin
        c.keep    = '{osc: 1'b1, atmr: 1'b1, adc: 1'b0, io: 1'b0, mem: 1'b0, cpu: 1'b0};
        c.wake_ok = 4'b1001;
        c.rkind   = RSTRT_FIXED;
      end
      default: ; // idle and reserved codes
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sleep_rst_sync.sv
module sleep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/sleep_wake_filter.sv
module sleep_wake_filter
  import sleep_ctrl_pkg::*;
(
  input  logic [NUM_WAKE-1:0] wake_src_i,
  input  logic [NUM_WAKE-1:0] wake_ok_i,
  output logic                wake_hit_o
);
  logic [NUM_WAKE-1:0] gated;

  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_src
    assign gated[g] = wake_src_i[g] & wake_ok_i[g];
  end

  assign wake_hit_o = |gated;
endmodule

// File: rtl/sleep_restart_timer.sv
module sleep_restart_timer #(
  parameter int CNT_W     = 16,
  parameter int FIXED_DLY = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             use_fixed_i,
  input  logic [CNT_W-1:0] prog_cnt_i,
  input  logic             run_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] FIXED_LOAD = CNT_W'(FIXED_DLY - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;

  always_comb begin
    if (use_fixed_i)              load_val = FIXED_LOAD;
    else if (prog_cnt_i == '0)    load_val = '0;
    else                          load_val = prog_cnt_i - CNT_W'(1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                     cnt_d = load_val;
    else if (run_i && cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_ctrl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sleep_req_i,
  input  mode_cfg_t req_cfg_i,
  input  logic      wake_hit_i,
  input  logic      tmr_done_i,
  output mode_cfg_t cfg_o,
  output logic      tmr_load_o,
  output logic      tmr_fixed_o,
  output logic      tmr_run_o,
  output clk_dom_t  dom_en_o,
  output logic      awake_o
);
  typedef enum logic [1:0] {ST_AWAKE, ST_ASLEEP, ST_RESTART} st_e;

  st_e       st_q, st_d;
  mode_cfg_t cfg_q, cfg_d;

  always_comb begin
    st_d       = st_q;
    cfg_d      = cfg_q;
    tmr_load_o = 1'b0;
    case (st_q)
      ST_AWAKE: begin
        if (sleep_req_i) begin
          st_d  = ST_ASLEEP;
          cfg_d = req_cfg_i;
        end
      end
      ST_ASLEEP: begin
        if (wake_hit_i) begin
          if (cfg_q.rkind == RSTRT_NONE) begin
            st_d = ST_AWAKE;
          end else begin
            st_d       = ST_RESTART;
            tmr_load_o = 1'b1;
          end
        end
      end
      ST_RESTART: begin
        if (tmr_done_i) st_d = ST_AWAKE;
      end
      default: st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_AWAKE;
      cfg_q <= '{keep: DOM_ALL_ON, wake_ok: '1, rkind: RSTRT_NONE};
    end else begin
      st_q  <= st_d;
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    dom_en_o = DOM_ALL_ON;
    case (st_q)
      ST_ASLEEP:  dom_en_o = cfg_q.keep;
      ST_RESTART: dom_en_o = '{osc: 1'b1, atmr: cfg_q.keep.atmr, adc: 1'b0,
                               io: 1'b0, mem: 1'b0, cpu: 1'b0};
      default:    dom_en_o = DOM_ALL_ON;
    endcase
  end

  assign cfg_o       = cfg_q;
  assign tmr_fixed_o = (cfg_q.rkind == RSTRT_FIXED);
  assign tmr_run_o   = (st_q == ST_RESTART);
  assign awake_o     = (st_q == ST_AWAKE);
endmodule

// File: rtl/sleep_clkgate_ctrl.sv
module sleep_clkgate_ctrl
  import sleep_ctrl_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int FIXED_DLY = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_en_i,
  input  logic [MODE_W-1:0] mode_sel_i,
  input  logic              sleep_strobe_i,
  input  logic [CNT_W-1:0]  startup_cnt_i,
  input  logic              wake_ext_i,
  input  logic              wake_periph_i,
  input  logic              wake_adc_i,
  input  logic              wake_atmr_i,
  output logic              clk_en_cpu_o,
  output logic              clk_en_mem_o,
  output logic              clk_en_io_o,
  output logic              clk_en_adc_o,
  output logic              clk_en_atmr_o,
  output logic              clk_en_osc_o,
  output logic              wake_ready_o
);
  logic      rst_sync_n;
  mode_cfg_t req_cfg, cur_cfg;
  logic      wake_hit, tmr_load, tmr_fixed, tmr_run, tmr_done, awake;
  clk_dom_t  dom_en;

  sleep_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  assign req_cfg = decode_mode(mode_sel_i);

  sleep_wake_filter u_wake_filter (
    .wake_src_i ({wake_atmr_i, wake_adc_i, wake_periph_i, wake_ext_i}),
    .wake_ok_i  (cur_cfg.wake_ok),
    .wake_hit_o (wake_hit)
  );

  sleep_restart_timer #(.CNT_W(CNT_W), .FIXED_DLY(FIXED_DLY)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .load_i      (tmr_load),
    .use_fixed_i (tmr_fixed),
    .prog_cnt_i  (startup_cnt_i),
    .run_i       (tmr_run),
    .done_o      (tmr_done)
  );

  sleep_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .sleep_req_i (sleep_strobe_i & sleep_en_i),
    .req_cfg_i   (req_cfg),
    .wake_hit_i  (wake_hit),
    .tmr_done_i  (tmr_done),
    .cfg_o       (cur_cfg),
    .tmr_load_o  (tmr_load),
    .tmr_fixed_o (tmr_fixed),
    .tmr_run_o   (tmr_run),
    .dom_en_o    (dom_en),
    .awake_o     (awake)
  );

  assign clk_en_cpu_o  = dom_en.cpu;
  assign clk_en_mem_o  = dom_en.mem;
  assign clk_en_io_o   = dom_en.io;
  assign clk_en_adc_o  = dom_en.adc;
  assign clk_en_atmr_o = dom_en.atmr;
  assign clk_en_osc_o  = dom_en.osc;
  assign wake_ready_o  = awake;
endmodule

// File: rtl/sleep_clkgate_ctrl_chk.sv
module sleep_clkgate_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_en_i,
  input logic sleep_strobe_i,
  input logic wake_ext_i,
  input logic clk_en_cpu_o,
  input logic clk_en_mem_o,
  input logic clk_en_io_o,
  input logic clk_en_adc_o,
  input logic clk_en_atmr_o,
  input logic clk_en_osc_o,
  input logic wake_ready_o
);
  // R2
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_ready_o && sleep_strobe_i && sleep_en_i) |=> (!wake_ready_o && !clk_en_cpu_o));

  // R2
  strobe_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_ready_o && sleep_strobe_i && !sleep_en_i) |=> wake_ready_o);

  // R5
  osc_off_gates_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_osc_o |-> !(clk_en_cpu_o || clk_en_mem_o || clk_en_io_o || clk_en_adc_o));

  // R7
  pdown_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_ready_o && !clk_en_osc_o && !clk_en_atmr_o && !wake_ext_i) |=> !wake_ready_o);

  // R9
  cpu_off_when_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_ready_o |-> !clk_en_cpu_o);

  // R9
  ready_all_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_ready_o |-> (clk_en_cpu_o && clk_en_mem_o && clk_en_io_o &&
                      clk_en_adc_o && clk_en_atmr_o && clk_en_osc_o));
endmodule

bind sleep_clkgate_ctrl sleep_clkgate_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sleep_en_i     (sleep_en_i),
  .sleep_strobe_i (sleep_strobe_i),
  .wake_ext_i     (wake_ext_i),
  .clk_en_cpu_o   (clk_en_cpu_o),
  .clk_en_mem_o   (clk_en_mem_o),
  .clk_en_io_o    (clk_en_io_o),
  .clk_en_adc_o   (clk_en_adc_o),
  .clk_en_atmr_o  (clk_en_atmr_o),
  .clk_en_osc_o   (clk_en_osc_o),
  .wake_ready_o   (wake_ready_o)
);

// File: tb/sleep_clkgate_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_clkgate_ctrl_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_ni;
  logic sleep_en, strobe;
  logic [2:0] mode_sel;
  logic [CNT_W-1:0] startup;
  logic [3:0] wake; // {atmr, adc, periph, ext}
  logic en_cpu, en_mem, en_io, en_adc, en_atmr, en_osc, ready;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sleep_clkgate_ctrl #(.CNT_W(CNT_W), .FIXED_DLY(6)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_en_i(sleep_en), .mode_sel_i(mode_sel),
    .sleep_strobe_i(strobe), .startup_cnt_i(startup),
    .wake_ext_i(wake[0]), .wake_periph_i(wake[1]), .wake_adc_i(wake[2]),
    .wake_atmr_i(wake[3]),
    .clk_en_cpu_o(en_cpu), .clk_en_mem_o(en_mem), .clk_en_io_o(en_io),
    .clk_en_adc_o(en_adc), .clk_en_atmr_o(en_atmr), .clk_en_osc_o(en_osc),
    .wake_ready_o(ready)
  );

  function automatic logic [5:0] en_bus();
    return {en_osc, en_atmr, en_adc, en_io, en_mem, en_cpu};
  endfunction

  function automatic logic [5:0] exp_keep(logic [2:0] m);
    case (m)
      3'b001:  return 6'b111000;
      3'b010:  return 6'b000000;
      3'b011:  return 6'b010000;
      3'b110:  return 6'b100000;
      3'b111:  return 6'b110000;
      default: return 6'b111110;
    endcase
  endfunction

  function automatic logic [3:0] exp_wake_ok(logic [2:0] m);
    case (m)
      3'b001:  return 4'b1101;
      3'b010:  return 4'b0001;
      3'b011:  return 4'b1001;
      3'b110:  return 4'b0001;
      3'b111:  return 4'b1001;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int exp_delay(logic [2:0] m, int n);
    case (m)
      3'b010, 3'b011: return (n == 0) ? 1 : n;
      3'b110, 3'b111: return 6;
      default:        return 0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sleep_cycle(logic [2:0] m, int n);
    logic [3:0] ok, bad, pick;
    int cnt;
    mode_sel = m; startup = CNT_W'(n); sleep_en = 1'b1; strobe = 1'b1;
    tick();
    strobe = 1'b0;
    // R3 R4 R5 R6 sleep mask; R2 entry
    chk($sformatf("R2/R3-mask mode=%0d", m), {26'd0, en_bus()}, {26'd0, exp_keep(m)});
    chk("R2 asleep", {31'd0, ready}, 32'd0);
    // R2 strobe while asleep has no effect on the mask
    strobe = 1'b1; mode_sel = 3'b000;
    tick();
    strobe = 1'b0;
    chk("R2 strobe asleep", {26'd0, en_bus()}, {26'd0, exp_keep(m)});
    ok = exp_wake_ok(m);
    bad = ~ok;
    if (bad != 4'b0) begin
      pick = 4'($urandom) & bad;
      if (pick == 4'b0) pick = bad & (~bad + 4'd1);
      wake = pick;
      tick();
      wake = 4'b0;
      // R7 disallowed source ignored
      chk($sformatf("R7 ignored mode=%0d src=%0b", m, pick), {26'd0, en_bus()}, {26'd0, exp_keep(m)});
      chk("R7 still asleep", {31'd0, ready}, 32'd0);
    end
    pick = 4'($urandom) & ok;
    if (pick == 4'b0) pick = ok & (~ok + 4'd1);
    wake = pick;
    tick();
    wake = 4'b0;
    cnt = 0;
    while (!ready && cnt < 100) begin
      // R9 restart pattern
      chk("R9 restart enables", {26'd0, en_bus()}, {26'd0, 1'b1, exp_keep(m)[4], 4'b0000});
      cnt++;
      tick();
    end
    // R8 delay
    chk($sformatf("R8 delay mode=%0d n=%0d", m, n), cnt, exp_delay(m, n));
    // R9 awake all on
    chk("R9 awake enables", {26'd0, en_bus()}, 32'h3F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [8];
    void'($urandom(32'd20240611));
    codes = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};
    rst_ni = 1'b0; sleep_en = 1'b0; strobe = 1'b0; mode_sel = '0;
    startup = '0; wake = '0;
    #23;
    // R1 reset state
    chk("R1 reset enables", {26'd0, en_bus()}, 32'h3F);
    chk("R1 reset ready", {31'd0, ready}, 32'd1);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) tick();

    // R2 strobe without enable is ignored
    sleep_en = 1'b0; strobe = 1'b1; mode_sel = 3'b010;
    tick();
    strobe = 1'b0;
    chk("R2 no-enable ready", {31'd0, ready}, 32'd1);
    chk("R2 no-enable enables", {26'd0, en_bus()}, 32'h3F);

    // directed corners
    sleep_cycle(3'b010, 0);   // R8 zero start-up count
    sleep_cycle(3'b011, 9);
    sleep_cycle(3'b100, 3);   // R3 reserved
    sleep_cycle(3'b101, 3);   // R3 reserved
    sleep_cycle(3'b110, 40);  // R6 fixed delay ignores count
    sleep_cycle(3'b111, 1);
    sleep_cycle(3'b001, 5);   // R4
    sleep_cycle(3'b000, 2);

    // random mix
    for (int i = 0; i < 40; i++) begin
      sleep_cycle(codes[$urandom % 8], int'($urandom % 16));
    end

    // R1 async reset while in power-down
    mode_sel = 3'b010; sleep_en = 1'b1; strobe = 1'b1;
    tick();
    strobe = 1'b0;
    chk("R1 pre-reset asleep", {26'd0, en_bus()}, 32'h00);
    #2 rst_ni = 1'b0;
    #1;
    chk("R1 async enables", {26'd0, en_bus()}, 32'h3F);
    chk("R1 async ready", {31'd0, ready}, 32'd1);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) tick();
    chk("R1 after release", {26'd0, en_bus()}, 32'h3F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule